// File: doc/BRIEF.md
# SRAM March-Style Test Sequencer

This block drives an external 256-word, 4-bit static RAM through a fixed self-test and reports the result. The RAM has an 8-bit address, separate data-in and data-out buses, an active-high write strobe and an active-low output enable. Its data-out bus floats whenever the output enable is released. A single start pulse runs the whole test with no further input.

The run has two phases. The single-line phase checks each data line on its own at address 0x00. The pattern phase then walks a thermometer-coded address set twice: the first pass writes Gray-code values and the second writes their complements. Every write and every read is broken into control steps, and each step lasts a configurable number of clock cycles. The first miscompare is captured with its address, expected value and observed value. The run always completes, and a one-cycle done pulse marks the end.

Top module: `sram_march_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle within one clock. In idle, `ram_we` is 0, `ram_oe_n` is 1, `done` and `fail` are 0, the three failure fields are 0 and a run in progress is dropped.
- R2: A `start` pulse in idle launches a run and clears any failure record from a previous run.
- R3: The single-line phase handles data bits 0, 1, 2 and 3 in that order, all at address 0x00. For each bit it writes 0 and reads it back, then writes 1 and reads it back. All other `ram_din` lines are driven to 0, and the compare looks only at the bit under test.
- R4: The pattern phase uses the addresses 0x00, 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x7F, 0xFF in that order. Each address sets one more bit from the LSB.
- R5: The first pass writes all nine addresses with 0x0, 0x1, 0x3, 0x2, 0x6, 0x7, 0x5, 0x4, 0xC and then reads all nine back. The second pass writes the bitwise complement of each value and then reads all nine back.
- R6: A write takes four steps: (1) address only, (2) data driven, (3) `ram_we` high, (4) `ram_we` low. `ram_oe_n` stays 1 for the whole write. Address and data do not change while `ram_we` is high.
- R7: A read takes three steps with `ram_we` at 0 throughout. `ram_oe_n` is 0 only in the second step. The data-out bus is sampled on the last cycle of that step.
- R8: Every step lasts `STEP_CYC` cycles, so the write strobe is exactly `STEP_CYC` cycles wide. `done` rises 182·`STEP_CYC` clocks after the clock edge that accepts `start`. It stays high for one cycle and then the block returns to idle with the bus released.
- R9: On the first miscompare, `fail` goes to 1 and stays there until the next start or reset. `fail_addr`, `fail_exp` and `fail_obs` latch the address, the masked expected value and the masked observed value, and later miscompares leave them unchanged. The run continues to the end.
- R10: With a fault-free RAM, `fail` is 0 when `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken in idle |
| ram_addr | output | 8 | RAM address |
| ram_din | output | 4 | RAM write data |
| ram_we | output | 1 | RAM write strobe, active high |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dout | input | 4 | RAM read data, floating when output is disabled |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky miscompare flag |
| fail_addr | output | 8 | Address of first miscompare |
| fail_exp | output | 4 | Masked expected value of first miscompare |
| fail_obs | output | 4 | Masked observed value of first miscompare |

## Verification
The properties assume `rst` is held high for the first clock, so the history-based checks start from a known idle state. They also assume `start` is the only thing that clears a latched failure. The bench holds `rst` high for several cycles before anything else and changes `start` and `rst` only on falling edges. The RAM stub returns valid read data only from the second cycle of output enable onward, so a sample taken too early shows up as a miscompare. Faults are injected only in the stub, never through the design's inputs.

// File: rtl/sram_test_pkg.sv
package sram_test_pkg;

    parameter int RAM_AW = 8;
    parameter int RAM_DW = 4;

    localparam int NUM_PAT   = RAM_AW + 1;
    localparam int BIT_OPS   = RAM_DW * 4;
    localparam int PAT_OPS   = 4 * NUM_PAT;
    localparam int TOTAL_OPS = BIT_OPS + PAT_OPS;
    localparam int OP_W      = $clog2(TOTAL_OPS);
    localparam int WR_STEPS  = 4;
    localparam int RD_STEPS  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [RAM_AW-1:0] addr;
        logic [RAM_DW-1:0] data;
        logic [RAM_DW-1:0] mask;
    } mem_op_t;

    function automatic logic [RAM_AW-1:0] thermo_addr(input int i);
        logic [RAM_AW-1:0] r;
        for (int b = 0; b < RAM_AW; b++) begin
            r[b] = (b < i);
        end
        return r;
    endfunction

    function automatic logic [RAM_DW-1:0] gray_word(input int i);
        logic [RAM_DW-1:0] v;
        v = RAM_DW'(i);
        return v ^ (v >> 1);
    endfunction

    function automatic mem_op_t decode_op(input int idx);
        mem_op_t o;
        int b, v, j, p, k;
        o = '0;
        if (idx < BIT_OPS) begin
            b      = idx / 4;
            v      = (idx / 2) % 2;
            o.wr   = ((idx % 2) == 0);
            o.addr = '0;
            o.mask = RAM_DW'(1) << b;
            o.data = (v == 1) ? o.mask : '0;
        end else begin
            j      = idx - BIT_OPS;
            p      = j / (2 * NUM_PAT);
            k      = j % (2 * NUM_PAT);
            o.wr   = (k < NUM_PAT);
            o.addr = thermo_addr(k % NUM_PAT);
            o.data = gray_word(k % NUM_PAT) ^ {RAM_DW{(p == 1)}};
            o.mask = '1;
        end
        return o;
    endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import sram_test_pkg::*;
#(
    parameter int STEP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cur_wr,
    output seq_state_e       state,
    output logic [OP_W-1:0]  op_idx,
    output logic [1:0]       step_idx,
    output logic             last_cyc,
    output logic             accept
);
    localparam int CYC_W = $clog2(STEP_CYC + 1);

    logic [CYC_W-1:0] cyc;
    logic [1:0]       last_step;

    assign last_cyc  = (cyc == CYC_W'(STEP_CYC - 1));
    assign last_step = cur_wr ? 2'(WR_STEPS - 1) : 2'(RD_STEPS - 1);
    assign accept    = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_idx   <= '0;
            step_idx <= '0;
            cyc      <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        op_idx   <= '0;
                        step_idx <= '0;
                        cyc      <= '0;
                    end
                end
                ST_RUN: begin
                    if (last_cyc) begin
                        cyc <= '0;
                        if (step_idx == last_step) begin
                            step_idx <= '0;
                            if (op_idx == OP_W'(TOTAL_OPS - 1)) begin
                                state <= ST_FIN;
                            end else begin
                                op_idx <= op_idx + 1'b1;
                            end
                        end else begin
                            step_idx <= step_idx + 1'b1;
                        end
                    end else begin
                        cyc <= cyc + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_drive.sv
module bus_drive
    import sram_test_pkg::*;
(
    input  logic              running,
    input  mem_op_t           op,
    input  logic [1:0]        step_idx,
    input  logic              last_cyc,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [RAM_DW-1:0] ram_din,
    output logic              ram_we,
    output logic              ram_oe_n,
    output logic              sample_now
);
    always_comb begin
        ram_addr   = '0;
        ram_din    = '0;
        ram_we     = 1'b0;
        ram_oe_n   = 1'b1;
        sample_now = 1'b0;
        if (running) begin
            ram_addr = op.addr;
            if (op.wr) begin
                if (step_idx != 2'd0) ram_din = op.data;
                ram_we = (step_idx == 2'd2);
            end else begin
                ram_oe_n   = (step_idx != 2'd1);
                sample_now = (step_idx == 2'd1) && last_cyc;
            end
        end
    end
endmodule

// File: rtl/miscompare_trap.sv
module miscompare_trap
    import sram_test_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample_now,
    input  mem_op_t           op,
    input  logic [RAM_DW-1:0] ram_dout,
    output logic              fail,
    output logic [RAM_AW-1:0] fail_addr,
    output logic [RAM_DW-1:0] fail_exp,
    output logic [RAM_DW-1:0] fail_obs
);
    logic [RAM_DW-1:0] obs_m;
    logic [RAM_DW-1:0] exp_m;
    logic              mism;

    assign obs_m = ram_dout & op.mask;
    assign exp_m = op.data & op.mask;
    assign mism  = sample_now && (obs_m != exp_m);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_obs  <= '0;
        end else if (mism && !fail) begin
            fail      <= 1'b1;
            fail_addr <= op.addr;
            fail_exp  <= exp_m;
            fail_obs  <= obs_m;
        end
    end
endmodule

// File: rtl/sram_march_seq.sv
module sram_march_seq
    import sram_test_pkg::*;
#(
    parameter int STEP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [RAM_DW-1:0] ram_din,
    output logic              ram_we,
    output logic              ram_oe_n,
    input  logic [RAM_DW-1:0] ram_dout,
    output logic              done,
    output logic              fail,
    output logic [RAM_AW-1:0] fail_addr,
    output logic [RAM_DW-1:0] fail_exp,
    output logic [RAM_DW-1:0] fail_obs
);
    seq_state_e       state;
    logic [OP_W-1:0]  op_idx;
    logic [1:0]       step_idx;
    logic             last_cyc;
    logic             accept;
    logic             sample_now;
    mem_op_t          cur_op;

    always_comb cur_op = decode_op(int'(op_idx));

    seq_ctrl #(.STEP_CYC(STEP_CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cur_wr   (cur_op.wr),
        .state    (state),
        .op_idx   (op_idx),
        .step_idx (step_idx),
        .last_cyc (last_cyc),
        .accept   (accept)
    );

    bus_drive u_bus (
        .running    (state == ST_RUN),
        .op         (cur_op),
        .step_idx   (step_idx),
        .last_cyc   (last_cyc),
        .ram_addr   (ram_addr),
        .ram_din    (ram_din),
        .ram_we     (ram_we),
        .ram_oe_n   (ram_oe_n),
        .sample_now (sample_now)
    );

    miscompare_trap u_trap (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .sample_now (sample_now),
        .op         (cur_op),
        .ram_dout   (ram_dout),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_exp   (fail_exp),
        .fail_obs   (fail_obs)
    );

    assign done = (state == ST_FIN);
endmodule

// File: rtl/sram_march_chk.sv
module sram_march_chk
    import sram_test_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [RAM_AW-1:0] ram_addr,
    input logic [RAM_DW-1:0] ram_din,
    input logic              ram_we,
    input logic              ram_oe_n,
    input logic              done,
    input logic              fail
);
    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (!ram_we && ram_oe_n && !done && !fail));

    // R6
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ram_oe_n);

    // R6
    we_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |-> ($stable(ram_addr) && $stable(ram_din)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ram_we && ram_oe_n));

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);
endmodule

bind sram_march_seq sram_march_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .ram_addr (ram_addr),
    .ram_din  (ram_din),
    .ram_we   (ram_we),
    .ram_oe_n (ram_oe_n),
    .done     (done),
    .fail     (fail)
);

// File: tb/tb_sram_march_seq.sv
module tb_sram_march_seq;
    localparam int STEP = 2;
    localparam int RUN_CYC = 182 * STEP;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] ram_addr;
    logic [3:0] ram_din;
    logic       ram_we;
    logic       ram_oe_n;
    wire  [3:0] ram_dout;
    logic       done, fail;
    logic [7:0] fail_addr;
    logic [3:0] fail_exp, fail_obs;

    always #10 clk = ~clk;

    sram_march_seq #(.STEP_CYC(STEP)) dut (
        .clk(clk), .rst(rst), .start(start),
        .ram_addr(ram_addr), .ram_din(ram_din), .ram_we(ram_we),
        .ram_oe_n(ram_oe_n), .ram_dout(ram_dout), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs)
    );

    // RAM stub with access delay and fault injection
    logic [3:0] mem [0:255];
    logic       oe_cnt = 1'b0;
    logic [3:0] stk_mask = 4'h0;
    logic [3:0] stk_val  = 4'h0;
    logic       alias_en = 1'b0;
    logic [3:0] word;

    initial for (int i = 0; i < 256; i++) mem[i] = 4'h0;

    always @(posedge clk) begin
        if (ram_we) begin
            mem[ram_addr] <= ram_din;
            if (alias_en && ram_addr == 8'hFF) mem[8'h7F] <= ram_din;
        end
        oe_cnt <= !ram_oe_n;
    end

    assign word = (mem[ram_addr] & ~stk_mask) | (stk_val & stk_mask);
    assign ram_dout = ram_oe_n ? 4'bzzzz : (oe_cnt ? word : ~word);

    // Scoreboard
    typedef struct { logic [7:0] addr; logic [3:0] data; } wr_item_t;
    wr_item_t   wq[$];
    logic [7:0] rq[$];
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_expect();
        logic [7:0] th [9] = '{8'h00, 8'h01, 8'h03, 8'h07, 8'h0F, 8'h1F, 8'h3F, 8'h7F, 8'hFF};
        logic [3:0] gr [9] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4, 4'hC};
        wr_item_t w;
        wq.delete();
        rq.delete();
        for (int b = 0; b < 4; b++) begin
            for (int v = 0; v < 2; v++) begin
                w.addr = 8'h00;
                w.data = (v == 1) ? (4'h1 << b) : 4'h0;
                wq.push_back(w);
                rq.push_back(8'h00);
            end
        end
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 9; k++) begin
                w.addr = th[k];
                w.data = gr[k] ^ ((p == 1) ? 4'hF : 4'h0);
                wq.push_back(w);
            end
            for (int k = 0; k < 9; k++) rq.push_back(th[k]);
        end
    endtask

    logic we_prev = 1'b0;
    logic oe_prev = 1'b1;
    int   we_len  = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we && !we_prev) begin
                chk(ram_oe_n == 1'b1, "R6 oe high at write strobe", ram_oe_n, 1);
                if (wq.size() == 0) begin
                    chk(1'b0, "R3/R5 unexpected write", ram_addr, 0);
                end else begin
                    wr_item_t w;
                    w = wq.pop_front();
                    chk(ram_addr == w.addr, "R4 write address", ram_addr, w.addr);
                    chk(ram_din == w.data, "R3/R5 write data", ram_din, w.data);
                end
            end
            if (ram_we) we_len++;
            if (!ram_we && we_prev) begin
                chk(we_len == STEP, "R8 strobe width", we_len, STEP);
                we_len = 0;
            end
            if (!ram_oe_n && oe_prev) begin
                chk(ram_we == 1'b0, "R7 we low during read", ram_we, 0);
                if (rq.size() == 0) begin
                    chk(1'b0, "R7 unexpected read", ram_addr, 0);
                end else begin
                    logic [7:0] a;
                    a = rq.pop_front();
                    chk(ram_addr == a, "R4 read address", ram_addr, a);
                end
            end
        end else begin
            we_len = 0;
        end
        we_prev = ram_we;
        oe_prev = ram_oe_n;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run_to_done(output int n);
        n = 0;
        while (n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic check_run_length(input int n);
        chk(n == RUN_CYC, "R8 run length", n, RUN_CYC);
        chk(wq.size() == 0 && rq.size() == 0, "R3/R5 all operations seen",
            wq.size() + rq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ram_we == 0 && ram_oe_n == 1, "R1 bus idle", {ram_we, ram_oe_n}, 2'b01);
        chk(done == 0 && fail == 0, "R1 flags clear", {done, fail}, 0);
        chk(fail_addr == 0 && fail_exp == 0 && fail_obs == 0, "R1 fields clear",
            {fail_addr, fail_exp, fail_obs}, 0);

        // Clean run: R10
        load_expect();
        pulse_start();
        run_to_done(n);
        chk(fail == 0, "R10 clean run passes", fail, 0);
        check_run_length(n);

        // Data bit 2 stuck at 1: first miss in single-line phase (R3, R9)
        stk_mask = 4'h4; stk_val = 4'h4;
        load_expect();
        pulse_start();
        run_to_done(n);
        chk(fail == 1, "R9 fail flag D2", fail, 1);
        chk(fail_addr == 8'h00, "R9 fail addr D2", fail_addr, 8'h00);
        chk(fail_exp == 4'h0, "R3 masked expected D2", fail_exp, 4'h0);
        chk(fail_obs == 4'h4, "R3 masked observed D2", fail_obs, 4'h4);
        check_run_length(n);

        // Clean run after a failing one: start clears record (R2)
        stk_mask = 4'h0;
        load_expect();
        pulse_start();
        chk(fail == 0 && fail_obs == 0, "R2 start clears record", fail, 0);
        run_to_done(n);
        chk(fail == 0, "R10 clean rerun passes", fail, 0);
        check_run_length(n);

        // Alias 0xFF onto 0x7F: first miss at 0x7F in pass one (R5, R9)
        alias_en = 1'b1;
        load_expect();
        pulse_start();
        run_to_done(n);
        chk(fail == 1, "R9 fail flag alias", fail, 1);
        chk(fail_addr == 8'h7F, "R9 first fail addr alias", fail_addr, 8'h7F);
        chk(fail_exp == 4'h4, "R5 pass-one expected", fail_exp, 4'h4);
        chk(fail_obs == 4'hC, "R9 observed alias", fail_obs, 4'hC);
        check_run_length(n);
        alias_en = 1'b0;

        // Data bit 0 stuck at 0 (R3)
        stk_mask = 4'h1; stk_val = 4'h0;
        load_expect();
        pulse_start();
        run_to_done(n);
        chk(fail == 1 && fail_addr == 8'h00, "R3 D0 stuck detected", fail, 1);
        chk(fail_exp == 4'h1 && fail_obs == 4'h0, "R3 D0 masked values",
            {fail_exp, fail_obs}, 8'h10);
        check_run_length(n);
        stk_mask = 4'h0;

        // Reset mid-run (R1)
        stk_mask = 4'h8; stk_val = 4'h8;
        load_expect();
        pulse_start();
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wq.delete();
        rq.delete();
        chk(ram_we == 0 && ram_oe_n == 1, "R1 bus idle after reset", {ram_we, ram_oe_n}, 2'b01);
        chk(fail == 0 && done == 0, "R1 flags after reset", {fail, done}, 0);
        n = 0;
        for (int i = 0; i < RUN_CYC + 20; i++) begin
            @(negedge clk);
            if (done || !ram_oe_n || ram_we) n++;
        end
        chk(n == 0, "R1 run dropped", n, 0);
        stk_mask = 4'h0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule